// File: doc/BRIEF.md
# Alarm Line Waveform Encoder

This block drives one alarm signal line and a matching isolated-output drive. It takes three error inputs, each already sorted into a priority class: non-masked, minor and major. A configuration bit picks one of two output behaviours.

In plain mode the line is a static level. It is high while no error is present and drops low as soon as any class is active. In coded mode the line carries a repeating waveform, and a remote receiver can tell the active error class from its shape:

- a long-high / short-low train means non-masked;
- a short-high / long-low train means minor;
- a steady low means major.

Timing is counted in ticks of a 1 kHz enable. By default a period is 980 + 20 ticks.

The isolated drive conducts (high) in the no-error condition and stops conducting whenever the line is low. It therefore follows the line level.

Top module: `alarm_encoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `alarm_line` and `opto_on` are both 1 (the no-error levels).
- R2: With `mode_coded`=0 and no error input active, `alarm_line` is 1.
- R3: With `mode_coded`=0 and any one or more of the three error inputs active, `alarm_line` is a steady 0, whatever the tick input does.
- R4: With `mode_coded`=1 and no error input active, `alarm_line` rests at 1.
- R5: With `mode_coded`=1 and only the non-masked error active, `alarm_line` repeats LONG_TICKS ticks at 1, then SHORT_TICKS ticks at 0, starting with the high phase.
- R6: With `mode_coded`=1 and the minor error active (major inactive), `alarm_line` repeats SHORT_TICKS ticks at 1, then LONG_TICKS ticks at 0, starting with the high phase.
- R7: With `mode_coded`=1 and the major error active, `alarm_line` is a steady 0.
- R8: When several error classes are active at once, major overrides minor, and minor overrides non-masked.
- R9: Whenever the selected output pattern changes, the phase count restarts from zero. The new pattern begins with a full high phase.
- R10: `opto_on` always equals `alarm_line`: it conducts (1) when the line is high and is off (0) when the line is low.
- R11: A change on the mode or error inputs reaches `alarm_line` two clock cycles after the edge that samples it.
- R12: The phase count advances only on cycles where `tick_ms`=1. Without ticks, the current level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle timing enable, nominally 1 kHz |
| mode_coded | input | 1 | 0 = plain static level, 1 = coded waveform |
| err_nonmasked | input | 1 | Non-masked class error active |
| err_minor | input | 1 | Minor class error active |
| err_major | input | 1 | Major class error active |
| alarm_line | output | 1 | Alarm signal line (1 = no error level) |
| opto_on | output | 1 | Isolated drive, 1 = conducting |

## Verification
The bench uses unequal short and long phase lengths. A design that swaps the two trains, or starts a train with its low phase, therefore shows a wrong level within one period.

It runs coded patterns with a sparse tick. A counter that ignores the enable would end each phase early.

It applies all error classes together and then drops the major one. A wrong priority order would then show the wrong train or a pulsing line where a steady low belongs.

It switches from one train to the other partway through a phase. A counter that failed to restart would produce a shortened first phase.

// File: rtl/alarm_enc_pkg.sv
package alarm_enc_pkg;
  typedef enum logic [1:0] {
    PAT_IDLE     = 2'd0,
    PAT_STEADY   = 2'd1,
    PAT_LONG_HI  = 2'd2,
    PAT_SHORT_HI = 2'd3
  } alarm_pat_e;
endpackage

// File: rtl/alarm_class_sel.sv
module alarm_class_sel
  import alarm_enc_pkg::*;
(
  input  logic       mode_coded,
  input  logic       err_nonmasked,
  input  logic       err_minor,
  input  logic       err_major,
  output alarm_pat_e pat_sel
);
  logic any_err;
  assign any_err = err_nonmasked | err_minor | err_major;

  always_comb begin
    if (!mode_coded) begin
      pat_sel = any_err ? PAT_STEADY : PAT_IDLE;
    end else if (err_major) begin
      pat_sel = PAT_STEADY;
    end else if (err_minor) begin
      pat_sel = PAT_SHORT_HI;
    end else if (err_nonmasked) begin
      pat_sel = PAT_LONG_HI;
    end else begin
      pat_sel = PAT_IDLE;
    end
  end
endmodule

// File: rtl/alarm_phase_ctr.sv
module alarm_phase_ctr
  import alarm_enc_pkg::*;
#(
  parameter int PERIOD_TICKS = 1000,
  parameter int CW           = $clog2(PERIOD_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_ms,
  input  alarm_pat_e    pat_sel,
  output alarm_pat_e    pat_q,
  output logic [CW-1:0] phase_cnt
);
  localparam logic [CW-1:0] LAST_C = CW'(PERIOD_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q     <= PAT_IDLE;
      phase_cnt <= '0;
    end else if (pat_sel != pat_q) begin
      pat_q     <= pat_sel;
      phase_cnt <= '0;
    end else if (tick_ms) begin
      phase_cnt <= (phase_cnt == LAST_C) ? '0 : phase_cnt + 1'b1;
    end
  end

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
    phase_cnt <= LAST_C);

  p_restart_on_change_r9: assert property (@(posedge clk) disable iff (rst)
    (pat_sel != pat_q) |=> (phase_cnt == '0));

  p_hold_without_tick_r12: assert property (@(posedge clk) disable iff (rst)
    (!tick_ms && pat_sel == pat_q) |=> $stable(phase_cnt));
endmodule

// File: rtl/alarm_wave_out.sv
module alarm_wave_out
  import alarm_enc_pkg::*;
#(
  parameter int LONG_TICKS  = 980,
  parameter int SHORT_TICKS = 20,
  parameter int CW          = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  alarm_pat_e    pat_q,
  input  logic [CW-1:0] phase_cnt,
  output logic          line_q,
  output logic          opto_q
);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_TICKS);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_TICKS);

  logic level_d;

  always_comb begin
    unique case (pat_q)
      PAT_IDLE:     level_d = 1'b1;
      PAT_STEADY:   level_d = 1'b0;
      PAT_LONG_HI:  level_d = (phase_cnt < LONG_C);
      PAT_SHORT_HI: level_d = (phase_cnt < SHORT_C);
      default:      level_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b1;
      opto_q <= 1'b1;
    end else begin
      line_q <= level_d;
      opto_q <= level_d;
    end
  end

  p_steady_low_r7: assert property (@(posedge clk) disable iff (rst)
    (pat_q == PAT_STEADY) |=> (!line_q && !opto_q));
endmodule

// File: rtl/alarm_encoder.sv
module alarm_encoder
  import alarm_enc_pkg::*;
#(
  parameter int LONG_TICKS  = 980,
  parameter int SHORT_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic mode_coded,
  input  logic err_nonmasked,
  input  logic err_minor,
  input  logic err_major,
  output logic alarm_line,
  output logic opto_on
);
  localparam int PERIOD_TICKS = LONG_TICKS + SHORT_TICKS;
  localparam int CW           = $clog2(PERIOD_TICKS);

  alarm_pat_e    pat_sel;
  alarm_pat_e    pat_q;
  logic [CW-1:0] phase_cnt;
  logic          any_err;

  assign any_err = err_nonmasked | err_minor | err_major;

  alarm_class_sel u_sel (
    .mode_coded   (mode_coded),
    .err_nonmasked(err_nonmasked),
    .err_minor    (err_minor),
    .err_major    (err_major),
    .pat_sel      (pat_sel)
  );

  alarm_phase_ctr #(.PERIOD_TICKS(PERIOD_TICKS), .CW(CW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .tick_ms  (tick_ms),
    .pat_sel  (pat_sel),
    .pat_q    (pat_q),
    .phase_cnt(phase_cnt)
  );

  alarm_wave_out #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS), .CW(CW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .pat_q    (pat_q),
    .phase_cnt(phase_cnt),
    .line_q   (alarm_line),
    .opto_q   (opto_on)
  );

  p_plain_err_low_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_coded && any_err) ##1 (!mode_coded && any_err) |=> !alarm_line);

  p_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
    (!any_err) ##1 (!any_err) |=> alarm_line);

  p_major_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (err_major) ##1 (err_major) |=> !alarm_line);
endmodule

// File: tb/tb_alarm_encoder.sv
`timescale 1ns/1ps
module tb_alarm_encoder;
  localparam int LONG  = 7;
  localparam int SHORT = 3;
  localparam int PER   = LONG + SHORT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0;
  logic mode_coded = 1'b0;
  logic err_nonmasked = 1'b0;
  logic err_minor = 1'b0;
  logic err_major = 1'b0;
  logic alarm_line, opto_on;

  int checks = 0;
  int fails  = 0;
  int cur_tdiv = 1;
  bit done = 0;

  always #2 clk = ~clk;

  alarm_encoder #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .mode_coded(mode_coded),
    .err_nonmasked(err_nonmasked), .err_minor(err_minor), .err_major(err_major),
    .alarm_line(alarm_line), .opto_on(opto_on)
  );

  // Reference model: 0 idle, 1 steady low, 2 long-high train, 3 short-high train
  bit    exp_q[$];
  string tag_q[$];
  int    mp = 0;
  int    mc = 0;
  bit    just_changed = 0;

  function automatic int want_pat();
    bit any;
    any = err_nonmasked | err_minor | err_major;
    if (!mode_coded) return any ? 1 : 0;
    if (err_major) return 1;
    if (err_minor) return 3;
    if (err_nonmasked) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit e;
    string t;
    int pd;
    if (rst) begin
      e = 1'b1; t = "R1";
      mp = 0; mc = 0; just_changed = 0;
    end else begin
      case (mp)
        0: begin e = 1'b1; t = mode_coded ? "R4" : "R2"; end
        1: begin e = 1'b0; t = (mode_coded && !err_major) ? "R8" : (mode_coded ? "R7" : "R3"); end
        2: begin e = (mc < LONG); t = (cur_tdiv > 1) ? "R12" : "R5"; end
        default: begin e = (mc < SHORT); t = err_nonmasked ? "R8" : ((cur_tdiv > 1) ? "R12" : "R6"); end
      endcase
      if (just_changed) t = {t, " R9/R11"};
      pd = want_pat();
      if (pd != mp) begin
        mp = pd; mc = 0; just_changed = 1;
      end else begin
        just_changed = 0;
        if (tick_ms) mc = (mc == PER - 1) ? 0 : mc + 1;
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    bit e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (alarm_line !== e) begin
        fails++;
        $display("FAIL %s alarm_line actual=%b expected=%b at %0t", t, alarm_line, e, $time);
      end
      checks++;
      if (opto_on !== e) begin
        fails++;
        $display("FAIL R10 opto_on actual=%b expected=%b at %0t", opto_on, e, $time);
      end
    end
  end

  task automatic drive(bit m, bit nm, bit mi, bit ma, int tdiv, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mode_coded = m; err_nonmasked = nm; err_minor = mi; err_major = ma;
      cur_tdiv = tdiv;
      tick_ms = (tdiv <= 1) ? 1'b1 : ((i % tdiv) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive(0, 0, 0, 0, 1, 5);    // R2
    drive(0, 1, 0, 0, 1, 6);    // R3 non-masked alone
    drive(0, 0, 0, 1, 1, 5);    // R3 major
    drive(0, 0, 1, 0, 2, 5);    // R3 minor, sparse tick
    drive(1, 0, 0, 0, 1, 5);    // R4
    drive(1, 1, 0, 0, 1, 25);   // R5
    drive(1, 0, 1, 0, 1, 25);   // R6
    drive(1, 0, 0, 1, 1, 8);    // R7
    drive(1, 1, 1, 1, 1, 6);    // R8 all active
    drive(1, 1, 1, 0, 1, 14);   // R8 minor over non-masked
    drive(1, 1, 0, 0, 3, 40);   // R12 sparse tick
    drive(1, 0, 1, 0, 2, 30);   // R12
    drive(1, 1, 0, 0, 1, 4);    // R9 switch mid-phase
    drive(1, 0, 1, 0, 1, 2);
    drive(1, 1, 0, 0, 1, 15);
    drive(0, 0, 0, 0, 1, 3);
    @(negedge clk); rst = 1'b1;  // R1 mid-run reset
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    drive(0, 0, 0, 0, 1, 4);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule